// File: doc/BRIEF.md
# Per-PE Matching Tuple Filter

This block sits inside one processing element of a multi-element graph accelerator. Each input beat delivers eight update tuples, each made of a destination, a value and a precomputed hash that names the processing element meant to handle it. The block keeps only the tuples whose hash equals its own element identifier and emits them one per cycle.

The block builds a match mask from the eight hashes. A decoder turns the mask into a count of matching lanes and a packed list of their lane numbers. A sequential filter then walks that list. A beat therefore costs exactly as many output cycles as it has matching tuples. A beat with no matches is taken in and costs no output cycle.

Both sides use valid/ready handshakes. The next beat is taken on the same cycle that the last matching tuple of the current beat leaves the block. This allows back-to-back beats with no gap on the output.

Top module: `tuple_filter`

## Requirements
- R1: Lane i of a beat matches when its hash field (bits i*HASH_W upward of `in_hash_i`) equals the parameter `PE_ID`. Only matching lanes are ever emitted.
- R2: The decoder produces a count equal to the number of matching lanes. It also produces a position list of 4-bit digits, with digit k holding the lane index of the k-th matching lane in ascending order and unused digits zero. Mask 0x44 gives count 2 and list 0x00000062. Mask 0xFF gives count 8 and list 0x76543210. Mask 0x00 gives count 0 and list 0.
- R3: The matching tuples of a beat leave in ascending lane order. Each carries the destination and value of its lane unchanged, and the beats keep their arrival order.
- R4: After a beat is accepted, its matching tuples are presented from the next cycle onward with `out_valid_o` high on every cycle, with no idle cycle between them, until all are transferred.
- R5: A beat with no matching lane is accepted and produces no output cycle.
- R6: `in_ready_o` is high when no tuple is pending, or when exactly one is pending and `out_ready_i` is high. It is low otherwise.
- R7: While `out_valid_o` is high and `out_ready_i` is low, the presented tuple is held unchanged on the next cycle.
- R8: After reset, `out_valid_o` is low and `in_ready_o` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_valid_i | input | 1 | Input beat valid |
| in_ready_o | output | 1 | Block can take a beat |
| in_dst_i | input | LANES*DST_W | Destinations, lane i at bits i*DST_W |
| in_val_i | input | LANES*VAL_W | Values, lane i at bits i*VAL_W |
| in_hash_i | input | LANES*HASH_W | Destination-element hashes, lane i at bits i*HASH_W |
| out_valid_o | output | 1 | Emitted tuple valid |
| out_ready_i | input | 1 | Downstream can take a tuple |
| out_dst_o | output | DST_W | Emitted destination |
| out_val_o | output | VAL_W | Emitted value |

## Verification
The assertions check on every cycle that the decoder's count equals the population of the mask and that each listed digit points at a set mask bit. They also check that a stalled output holds its tuple, that the walk index stays below the count, and that lanes within a beat are emitted in rising order. Only the bench scenarios can show that the right tuples come out with no gaps and that no-match beats are absorbed. They also show that a new beat is taken on the very cycle the previous one finishes, under both a steady and an irregular downstream ready.

// File: rtl/tf_pkg.sv
package tf_pkg;
  // digit wide enough for any lane index, plus one spare bit
  function automatic int unsigned digit_w(int unsigned lanes);
    return $clog2(lanes) + 1;
  endfunction

  function automatic int unsigned count_w(int unsigned lanes);
    return $clog2(lanes + 1);
  endfunction
endpackage

// File: rtl/tf_mask_build.sv
module tf_mask_build #(
  parameter int unsigned LANES  = 8,
  parameter int unsigned HASH_W = 3,
  parameter int unsigned PE_ID  = 0
) (
  input  logic [LANES*HASH_W-1:0] hash_i,
  output logic [LANES-1:0]        mask_o
);
  localparam logic [HASH_W-1:0] ID = HASH_W'(PE_ID);

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign mask_o[g] = (hash_i[g*HASH_W +: HASH_W] == ID);
  end
endmodule

// File: rtl/tf_pos_decode.sv
module tf_pos_decode
  import tf_pkg::*;
#(
  parameter int unsigned LANES   = 8,
  localparam int unsigned DIGIT_W = digit_w(LANES),
  localparam int unsigned CNT_W   = count_w(LANES)
) (
  input  logic [LANES-1:0]         mask_i,
  output logic [CNT_W-1:0]         cnt_o,
  output logic [LANES*DIGIT_W-1:0] pos_o
);
  always_comb begin
    int k;
    k     = 0;
    pos_o = '0;
    for (int i = 0; i < LANES; i++) begin
      if (mask_i[i]) begin
        pos_o[k*DIGIT_W +: DIGIT_W] = DIGIT_W'(i);
        k = k + 1;
      end
    end
    cnt_o = CNT_W'(k);
  end

  always_comb begin
    if (!$isunknown(mask_i)) begin
      AST_CNT_POPCOUNT: assert (int'(cnt_o) == $countones(mask_i)); // R2
      for (int k = 0; k < LANES; k++) begin
        if (k < int'(cnt_o)) begin
          AST_DIGIT_HITS_MASK: assert (mask_i[pos_o[k*DIGIT_W +: DIGIT_W]]); // R2
        end
      end
    end
  end
endmodule

// File: rtl/tf_seq_filter.sv
module tf_seq_filter
  import tf_pkg::*;
#(
  parameter int unsigned LANES   = 8,
  parameter int unsigned DST_W   = 16,
  parameter int unsigned VAL_W   = 32,
  localparam int unsigned DIGIT_W = digit_w(LANES),
  localparam int unsigned CNT_W   = count_w(LANES)
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     in_valid_i,
  output logic                     in_ready_o,
  input  logic [LANES*DST_W-1:0]   in_dst_i,
  input  logic [LANES*VAL_W-1:0]   in_val_i,
  input  logic [CNT_W-1:0]         cnt_i,
  input  logic [LANES*DIGIT_W-1:0] pos_i,
  output logic                     out_valid_o,
  input  logic                     out_ready_i,
  output logic [DST_W-1:0]         out_dst_o,
  output logic [VAL_W-1:0]         out_val_o
);
  logic                     busy_q;
  logic [CNT_W-1:0]         cnt_q, idx_q;
  logic [LANES*DIGIT_W-1:0] pos_q;
  logic [LANES*DST_W-1:0]   dst_q;
  logic [LANES*VAL_W-1:0]   val_q;
  logic [DIGIT_W-1:0]       cur_lane;
  logic                     last, out_fire, in_fire;

  assign cur_lane    = pos_q[int'(idx_q)*DIGIT_W +: DIGIT_W];
  assign last        = (idx_q == cnt_q - 1'b1);
  assign out_valid_o = busy_q;
  assign out_fire    = busy_q && out_ready_i;
  assign in_ready_o  = !busy_q || (out_fire && last);
  assign in_fire     = in_valid_i && in_ready_o;
  assign out_dst_o   = dst_q[int'(cur_lane)*DST_W +: DST_W];
  assign out_val_o   = val_q[int'(cur_lane)*VAL_W +: VAL_W];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
      idx_q  <= '0;
      pos_q  <= '0;
      dst_q  <= '0;
      val_q  <= '0;
    end else if (in_fire && cnt_i != '0) begin
      busy_q <= 1'b1;
      cnt_q  <= cnt_i;
      idx_q  <= '0;
      pos_q  <= pos_i;
      dst_q  <= in_dst_i;
      val_q  <= in_val_i;
    end else if (out_fire) begin
      if (last) busy_q <= 1'b0;
      else      idx_q  <= idx_q + 1'b1;
    end
  end

  AST_OUT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o && !out_ready_i |=> out_valid_o && $stable(out_dst_o) && $stable(out_val_o)); // R7
  AST_IDX_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_q |-> (idx_q < cnt_q)); // R4
  AST_LANE_RISING: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_fire && !last |=> out_valid_o && (cur_lane > $past(cur_lane))); // R3
endmodule

// File: rtl/tuple_filter.sv
module tuple_filter
  import tf_pkg::*;
#(
  parameter int unsigned LANES  = 8,
  parameter int unsigned DST_W  = 16,
  parameter int unsigned VAL_W  = 32,
  parameter int unsigned HASH_W = 3,
  parameter int unsigned PE_ID  = 0
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    in_valid_i,
  output logic                    in_ready_o,
  input  logic [LANES*DST_W-1:0]  in_dst_i,
  input  logic [LANES*VAL_W-1:0]  in_val_i,
  input  logic [LANES*HASH_W-1:0] in_hash_i,
  output logic                    out_valid_o,
  input  logic                    out_ready_i,
  output logic [DST_W-1:0]        out_dst_o,
  output logic [VAL_W-1:0]        out_val_o
);
  localparam int unsigned DIGIT_W = digit_w(LANES);
  localparam int unsigned CNT_W   = count_w(LANES);

  logic [LANES-1:0]         mask;
  logic [CNT_W-1:0]         cnt;
  logic [LANES*DIGIT_W-1:0] pos;

  tf_mask_build #(.LANES(LANES), .HASH_W(HASH_W), .PE_ID(PE_ID)) u_mask (
    .hash_i (in_hash_i),
    .mask_o (mask)
  );

  tf_pos_decode #(.LANES(LANES)) u_dec (
    .mask_i (mask),
    .cnt_o  (cnt),
    .pos_o  (pos)
  );

  tf_seq_filter #(.LANES(LANES), .DST_W(DST_W), .VAL_W(VAL_W)) u_filt (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .in_valid_i  (in_valid_i),
    .in_ready_o  (in_ready_o),
    .in_dst_i    (in_dst_i),
    .in_val_i    (in_val_i),
    .cnt_i       (cnt),
    .pos_i       (pos),
    .out_valid_o (out_valid_o),
    .out_ready_i (out_ready_i),
    .out_dst_o   (out_dst_o),
    .out_val_o   (out_val_o)
  );
endmodule

// File: tb/tuple_filter_tb_top.sv
module tuple_filter_tb_top;
  localparam int LANES  = 8;
  localparam int DST_W  = 16;
  localparam int VAL_W  = 32;
  localparam int HASH_W = 3;
  localparam int PE_ID  = 5;
  localparam int NBEATS = 300;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic in_valid_i = 1'b0;
  logic in_ready_o;
  logic [LANES*DST_W-1:0]  in_dst_i  = '0;
  logic [LANES*VAL_W-1:0]  in_val_i  = '0;
  logic [LANES*HASH_W-1:0] in_hash_i = '0;
  logic out_valid_o;
  logic out_ready_i = 1'b0;
  logic [DST_W-1:0] out_dst_o;
  logic [VAL_W-1:0] out_val_o;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit done = 1'b0;

  always #2 clk_i = ~clk_i;

  tuple_filter #(.LANES(LANES), .DST_W(DST_W), .VAL_W(VAL_W), .HASH_W(HASH_W), .PE_ID(PE_ID)) dut_i (
    .clk_i, .rst_ni, .in_valid_i, .in_ready_o, .in_dst_i, .in_val_i, .in_hash_i,
    .out_valid_o, .out_ready_i, .out_dst_o, .out_val_o
  );

  logic [DST_W-1:0] exp_dst_q[$];
  logic [VAL_W-1:0] exp_val_q[$];
  logic [LANES-1:0] masks[NBEATS];

  task automatic chk(bit ok, string req, string what, longint act, longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic drive_beat(int b);
    for (int l = 0; l < LANES; l++) begin
      in_dst_i[l*DST_W +: DST_W] = DST_W'(b*16 + l);
      in_val_i[l*VAL_W +: VAL_W] = VAL_W'(b*1000 + l*7 + 3);
      in_hash_i[l*HASH_W +: HASH_W] = masks[b][l] ? HASH_W'(PE_ID)
                                                  : HASH_W'((PE_ID + 1 + (l % 7)) % 8);
    end
  endtask

  initial begin
    int b;
    int lfsr;
    bit prev_stall;
    logic [DST_W-1:0] prev_dst;
    logic [VAL_W-1:0] prev_val;
    bit exp_rdy;
    // directed masks first, then pseudo-random ones (R1, R2, R5)
    masks[0] = 8'h44; masks[1] = 8'hFF; masks[2] = 8'h00; masks[3] = 8'h01;
    masks[4] = 8'h80; masks[5] = 8'h00; masks[6] = 8'h00; masks[7] = 8'hAA;
    lfsr = 32'h1ACE;
    for (int i = 8; i < NBEATS; i++) begin
      lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
      masks[i] = lfsr[7:0] & ((i % 5 == 0) ? 8'h00 : 8'hFF);
    end

    // R8 reset state
    #1;
    chk(out_valid_o == 1'b0, "R8", "out_valid in reset", longint'(out_valid_o), 0);
    chk(in_ready_o == 1'b1, "R8", "in_ready in reset", longint'(in_ready_o), 1);
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk(out_valid_o == 1'b0, "R8", "out_valid after reset", longint'(out_valid_o), 0);
    chk(in_ready_o == 1'b1, "R8", "in_ready after reset", longint'(in_ready_o), 1);

    b = 0;
    prev_stall = 1'b0;
    prev_dst = '0;
    prev_val = '0;
    while (b < NBEATS || exp_dst_q.size() != 0) begin
      @(negedge clk_i);
      lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
      out_ready_i = (b < 60) ? 1'b1 : lfsr[3] | lfsr[9];
      in_valid_i  = (b < NBEATS) && ((b < 60) || lfsr[5] || lfsr[12]);
      if (b < NBEATS) drive_beat(b);
      #1;
      // R4: pending tuples must be presented, none invented
      chk(out_valid_o == (exp_dst_q.size() != 0), "R4", "out_valid vs pending",
          longint'(out_valid_o), longint'(exp_dst_q.size() != 0));
      if (prev_stall && out_valid_o) begin
        chk(out_dst_o == prev_dst && out_val_o == prev_val, "R7", "held dst",
            longint'(out_dst_o), longint'(prev_dst));
      end
      exp_rdy = (exp_dst_q.size() == 0) || (exp_dst_q.size() == 1 && out_ready_i);
      chk(in_ready_o == exp_rdy, "R6", "in_ready", longint'(in_ready_o), longint'(exp_rdy));
      if (out_valid_o && exp_dst_q.size() != 0) begin
        chk(out_dst_o == exp_dst_q[0], "R3", "dst", longint'(out_dst_o), longint'(exp_dst_q[0]));
        chk(out_val_o == exp_val_q[0], "R1", "val", longint'(out_val_o), longint'(exp_val_q[0]));
      end
      prev_stall = out_valid_o && !out_ready_i;
      prev_dst = out_dst_o;
      prev_val = out_val_o;
      if (out_valid_o && out_ready_i && exp_dst_q.size() != 0) begin
        void'(exp_dst_q.pop_front());
        void'(exp_val_q.pop_front());
      end
      if (in_valid_i && in_ready_o) begin
        // reference: scan lanes upward, keep matches (R2, R3, R5)
        for (int l = 0; l < LANES; l++) begin
          if (masks[b][l]) begin
            exp_dst_q.push_back(DST_W'(b*16 + l));
            exp_val_q.push_back(VAL_W'(b*1000 + l*7 + 3));
          end
        end
        b++;
      end
    end
    in_valid_i = 1'b0;
    repeat (2) @(negedge clk_i);
    chk(out_valid_o == 1'b0, "R5", "idle at end", longint'(out_valid_o), 0);
    done = 1'b1;
  end

  always @(posedge clk_i) begin
    cycles++;
    if (done || cycles > 20000) begin
      if (!done) begin
        checks++;
        errors++;
        $display("FAIL R4 watchdog: actual %0d expected below %0d", cycles, 20000);
      end
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule